// File: doc/BRIEF.md
# Descriptor List DMA Walker

This block is the DMA front end of a serial flash controller. A transfer is described in memory by a two-word record. The record holds the head pointer of a transmit job list and the head pointer of a receive job list. Each job is a pair of 32-bit words: a buffer address, then an attribute word. The low 24 bits of the attribute word give the byte count. The upper bits carry attribute and flag information, which this block does not act on. A job whose two words are both zero closes its list.

Software writes the record address and pulses a start strobe. The walker then works through the transmit list and afterwards the receive list. It fetches every descriptor word through a single-outstanding read port. For transmit jobs it reads the buffer byte by byte and presents the bytes on an outgoing byte stream. For receive jobs it takes bytes from an incoming byte stream and stores them through a byte write port. When both lists are closed, it sets a sticky done flag that can raise an interrupt.

A transmit packet is normally built as three jobs (command, address, data), with the command and address jobs each given a length of 4. A receive-only packet uses an empty transmit list and a single receive data job.

Top module: `joblist_dma_walker`

## Requirements
- R1: After reset, `busy`, `done_flag`, `irq`, `rd_valid`, `wr_valid`, `tx_valid` and `rx_ready` are low. A `start` pulse while idle raises `busy` in the following cycle. The word at `list_ptr` is the transmit list head and the word at `list_ptr+4` is the receive list head.
- R2: A job at address J is read as the buffer address from J and the attribute word from J+4. The next job of the same list is at J+8, and jobs are carried out strictly in list order.
- R3: Bits 23:0 of the attribute word are the byte count of the job. Bits 31:24 have no effect on the number of bytes moved.
- R4: A job with both words zero ends its list. A list whose head is such a job moves no byte.
- R5: A job that is not null but has a zero byte count is skipped without any stream or write beat.
- R6: Transmit bytes are read from consecutive byte addresses starting at the buffer address. Byte lane `addr[1:0]` of the 32-bit read response is used, with lane 0 in bits 7:0. The bytes appear on `tx_byte` in order, and `tx_valid`/`tx_byte` hold while `tx_ready` is low.
- R7: Each byte accepted on the receive stream is written once, through the write port, to consecutive byte addresses starting at the buffer address. The write request holds while `wr_ready` is low.
- R8: Every transmit job completes before the first receive byte is written.
- R9: `done_flag` is set once both lists have ended and `busy` has fallen. It stays set until `clr_done` is pulsed, and `irq` is `done_flag` gated by `irq_en`.
- R10: A `start` pulse while `busy` is high has no effect on the walk in progress.
- R11: At most one read request is outstanding. `rd_valid` and `rd_addr` hold until `rd_ready`, and only one of the read, write, transmit and receive ports is active at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe, acted on only while idle |
| list_ptr | input | AW | Byte address of the transfer record |
| irq_en | input | 1 | Interrupt enable for the done flag |
| clr_done | input | 1 | Clears the done flag |
| busy | output | 1 | Walk in progress |
| done_flag | output | 1 | Sticky completion flag |
| irq | output | 1 | Interrupt request |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | AW | Read byte address |
| rsp_valid | input | 1 | Read response valid |
| rsp_data | input | 32 | Read response word |
| wr_valid | output | 1 | Byte write request valid |
| wr_ready | input | 1 | Byte write accepted |
| wr_addr | output | AW | Byte write address |
| wr_byte | output | 8 | Byte to write |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_ready | input | 1 | Outgoing byte accepted |
| tx_byte | output | 8 | Outgoing byte |
| rx_valid | input | 1 | Incoming byte valid |
| rx_ready | output | 1 | Walker takes an incoming byte |
| rx_byte | input | 8 | Incoming byte |

## Verification
The bench builds the walker with a 16-bit address width and little-endian lane order. With that width, every record, job and buffer fits in a small model memory, and unaligned buffers exercise each of the four response lanes. The bench can turn on backpressure that periodically stalls the read, write and both stream ports. This reaches the hold conditions of R6, R7 and R11 and lets a start pulse land in the middle of a long walk. A single record with both lists non-empty and receive bytes queued from the outset shows whether any receive write slips ahead of the transmit jobs.

// File: rtl/wlk_pkg.sv
package wlk_pkg;
   localparam int WORD_W      = 32;
   localparam int LEN_W       = 24;
   localparam int JOB_STRIDE  = 8;
   localparam int ATTR_OFS    = 4;
   localparam int RX_HEAD_OFS = 4;

   typedef enum logic [3:0] {
      S_IDLE,
      S_REC_REQ,
      S_REC_RSP,
      S_JA_REQ,
      S_JA_RSP,
      S_JB_REQ,
      S_JB_RSP,
      S_EVAL,
      S_TX_REQ,
      S_TX_RSP,
      S_TX_OUT,
      S_RX_IN,
      S_RX_WR,
      S_FIN
   } wlk_state_e;

   typedef enum logic {
      SIDE_TX = 1'b0,
      SIDE_RX = 1'b1
   } wlk_side_e;
endpackage

// File: rtl/wlk_cursor.sv
module wlk_cursor
   import wlk_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_jptr,
   input  logic [AW-1:0]    jptr_in,
   input  logic             adv_jptr,
   input  logic             ld_buf,
   input  logic [AW-1:0]    buf_in,
   input  logic             buf_inc,
   input  logic             ld_len,
   input  logic [LEN_W-1:0] len_in,
   input  logic             len_dec,
   output logic [AW-1:0]    jptr,
   output logic [AW-1:0]    buf_addr,
   output logic [LEN_W-1:0] len_left,
   output logic             len_last
);
   localparam logic [AW-1:0]    STEP_JOB = AW'(JOB_STRIDE);
   localparam logic [AW-1:0]    STEP_BUF = AW'(1);
   localparam logic [LEN_W-1:0] ONE_LEN  = LEN_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         jptr     <= '0;
         buf_addr <= '0;
         len_left <= '0;
      end else begin
         if (ld_jptr)       jptr <= jptr_in;
         else if (adv_jptr) jptr <= jptr + STEP_JOB;

         if (ld_buf)       buf_addr <= buf_in;
         else if (buf_inc) buf_addr <= buf_addr + STEP_BUF;

         if (ld_len)       len_left <= len_in;
         else if (len_dec) len_left <= len_left - ONE_LEN;
      end
   end

   assign len_last = (len_left == ONE_LEN);

   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      len_dec |-> (len_left != '0)); // R3
   AST_JOB_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      adv_jptr && !ld_jptr |=> jptr != $past(jptr)); // R2
endmodule

// File: rtl/wlk_lane.sv
module wlk_lane
   import wlk_pkg::*;
#(
   parameter int BIG_LANES = 0
) (
   input  logic [WORD_W-1:0] word_i,
   input  logic [1:0]        sel_i,
   output logic [7:0]        byte_o
);
   if (BIG_LANES != 0 && BIG_LANES != 1) begin : g_bad_lanes
      $error("BIG_LANES must be 0 or 1");
   end

   if (BIG_LANES == 0) begin : g_little
      always_comb begin
         case (sel_i)
            2'd0:    byte_o = word_i[7:0];
            2'd1:    byte_o = word_i[15:8];
            2'd2:    byte_o = word_i[23:16];
            default: byte_o = word_i[31:24];
         endcase
      end
   end else begin : g_big
      always_comb begin
         case (sel_i)
            2'd0:    byte_o = word_i[31:24];
            2'd1:    byte_o = word_i[23:16];
            2'd2:    byte_o = word_i[15:8];
            default: byte_o = word_i[7:0];
         endcase
      end
   end
endmodule

// File: rtl/wlk_event.sv
module wlk_event (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic irq_en_i,
   output logic done_o,
   output logic irq_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     done_o <= 1'b0;
      else if (set_i) done_o <= 1'b1;
      else if (clr_i) done_o <= 1'b0;
   end

   assign irq_o = done_o & irq_en_i;

   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && !clr_i |=> done_o); // R9
   AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i && !set_i |=> !done_o); // R9
endmodule

// File: rtl/wlk_ctrl.sv
module wlk_ctrl
   import wlk_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [AW-1:0]     list_ptr,
   output logic              busy,
   output logic              done_set,
   output logic              rd_valid,
   input  logic              rd_ready,
   output logic [AW-1:0]     rd_addr,
   input  logic              rsp_valid,
   input  logic [WORD_W-1:0] rsp_data,
   output logic              wr_valid,
   input  logic              wr_ready,
   output logic [AW-1:0]     wr_addr,
   output logic [7:0]        wr_byte,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic [7:0]        tx_byte,
   input  logic              rx_valid,
   output logic              rx_ready,
   input  logic [7:0]        rx_byte,
   input  logic [7:0]        picked_byte,
   input  logic [AW-1:0]     jptr,
   input  logic [AW-1:0]     buf_addr,
   input  logic [LEN_W-1:0]  len_left,
   input  logic              len_last,
   output logic              ld_jptr,
   output logic [AW-1:0]     jptr_in,
   output logic              adv_jptr,
   output logic              ld_buf,
   output logic [AW-1:0]     buf_in,
   output logic              buf_inc,
   output logic              ld_len,
   output logic [LEN_W-1:0]  len_in,
   output logic              len_dec
);
   localparam logic [AW-1:0] HEAD_OFS = AW'(RX_HEAD_OFS);
   localparam logic [AW-1:0] ATTR_OFF = AW'(ATTR_OFS);

   wlk_state_e    state;
   wlk_side_e     side;
   logic [AW-1:0] rec_ptr;
   logic [7:0]    byte_q;
   logic          rx_last;
   logic          buf_zero;
   logic          attr_zero;
   logic          job_null;
   logic          tx_hs, rx_hs, wr_hs;

   assign job_null = buf_zero & attr_zero;
   assign tx_hs    = (state == S_TX_OUT) && tx_ready;
   assign rx_hs    = (state == S_RX_IN)  && rx_valid;
   assign wr_hs    = (state == S_RX_WR)  && wr_ready;

   // cursor commands
   always_comb begin
      ld_jptr  = (state == S_REC_RSP) && rsp_valid;
      ld_buf   = (state == S_JA_RSP)  && rsp_valid;
      ld_len   = (state == S_JB_RSP)  && rsp_valid;
      jptr_in  = rsp_data[AW-1:0];
      buf_in   = rsp_data[AW-1:0];
      len_in   = rsp_data[LEN_W-1:0];
      adv_jptr = ((state == S_EVAL) && !job_null && (len_left == '0))
               || (tx_hs && len_last) || (wr_hs && rx_last);
      buf_inc  = tx_hs || wr_hs;
      len_dec  = tx_hs || rx_hs;
   end

   // port drive
   always_comb begin
      rd_valid = 1'b0;
      rd_addr  = buf_addr;
      case (state)
         S_REC_REQ: begin
            rd_valid = 1'b1;
            rd_addr  = (side == SIDE_RX) ? rec_ptr + HEAD_OFS : rec_ptr;
         end
         S_JA_REQ: begin
            rd_valid = 1'b1;
            rd_addr  = jptr;
         end
         S_JB_REQ: begin
            rd_valid = 1'b1;
            rd_addr  = jptr + ATTR_OFF;
         end
         S_TX_REQ: begin
            rd_valid = 1'b1;
            rd_addr  = buf_addr;
         end
         default: ;
      endcase
   end

   assign tx_valid = (state == S_TX_OUT);
   assign tx_byte  = byte_q;
   assign rx_ready = (state == S_RX_IN);
   assign wr_valid = (state == S_RX_WR);
   assign wr_addr  = buf_addr;
   assign wr_byte  = byte_q;
   assign busy     = (state != S_IDLE);
   assign done_set = (state == S_FIN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         side      <= SIDE_TX;
         rec_ptr   <= '0;
         byte_q    <= '0;
         rx_last   <= 1'b0;
         buf_zero  <= 1'b0;
         attr_zero <= 1'b0;
      end else begin
         case (state)
            S_IDLE: if (start) begin
               rec_ptr <= list_ptr;
               side    <= SIDE_TX;
               state   <= S_REC_REQ;
            end
            S_REC_REQ: if (rd_ready)  state <= S_REC_RSP;
            S_REC_RSP: if (rsp_valid) state <= S_JA_REQ;
            S_JA_REQ:  if (rd_ready)  state <= S_JA_RSP;
            S_JA_RSP: if (rsp_valid) begin
               buf_zero <= (rsp_data == '0);
               state    <= S_JB_REQ;
            end
            S_JB_REQ: if (rd_ready) state <= S_JB_RSP;
            S_JB_RSP: if (rsp_valid) begin
               attr_zero <= (rsp_data == '0);
               state     <= S_EVAL;
            end
            S_EVAL: begin
               if (job_null) begin
                  if (side == SIDE_TX) begin
                     side  <= SIDE_RX;
                     state <= S_REC_REQ;
                  end else begin
                     state <= S_FIN;
                  end
               end else if (len_left == '0) begin
                  state <= S_JA_REQ;
               end else begin
                  state <= (side == SIDE_TX) ? S_TX_REQ : S_RX_IN;
               end
            end
            S_TX_REQ: if (rd_ready) state <= S_TX_RSP;
            S_TX_RSP: if (rsp_valid) begin
               byte_q <= picked_byte;
               state  <= S_TX_OUT;
            end
            S_TX_OUT: if (tx_ready) state <= len_last ? S_JA_REQ : S_TX_REQ;
            S_RX_IN: if (rx_valid) begin
               byte_q  <= rx_byte;
               rx_last <= len_last;
               state   <= S_RX_WR;
            end
            S_RX_WR: if (wr_ready) state <= rx_last ? S_JA_REQ : S_RX_IN;
            S_FIN:   state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr)); // R11
   AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_valid, wr_valid, tx_valid, rx_ready})); // R11
   AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte)); // R6
   AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_byte)); // R7
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      busy && start |=> $stable(rec_ptr)); // R10
   AST_RX_AFTER_TX: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> side == SIDE_TX); // R8
endmodule

// File: rtl/joblist_dma_walker.sv
module joblist_dma_walker
   import wlk_pkg::*;
#(
   parameter int AW        = 32,
   parameter int BIG_LANES = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] list_ptr,
   input  logic          irq_en,
   input  logic          clr_done,
   output logic          busy,
   output logic          done_flag,
   output logic          irq,
   output logic          rd_valid,
   input  logic          rd_ready,
   output logic [AW-1:0] rd_addr,
   input  logic          rsp_valid,
   input  logic [31:0]   rsp_data,
   output logic          wr_valid,
   input  logic          wr_ready,
   output logic [AW-1:0] wr_addr,
   output logic [7:0]    wr_byte,
   output logic          tx_valid,
   input  logic          tx_ready,
   output logic [7:0]    tx_byte,
   input  logic          rx_valid,
   output logic          rx_ready,
   input  logic [7:0]    rx_byte
);
   if (AW < 12 || AW > WORD_W) begin : g_bad_aw
      $error("AW must lie between 12 and 32");
   end

   logic             done_set;
   logic [7:0]       picked_byte;
   logic [AW-1:0]    jptr, buf_addr, jptr_in, buf_in;
   logic [LEN_W-1:0] len_left, len_in;
   logic             len_last, ld_jptr, adv_jptr, ld_buf, buf_inc, ld_len, len_dec;

   wlk_ctrl #(.AW(AW)) u_ctrl (
      .clk, .rst_n, .start, .list_ptr, .busy, .done_set,
      .rd_valid, .rd_ready, .rd_addr, .rsp_valid, .rsp_data,
      .wr_valid, .wr_ready, .wr_addr, .wr_byte,
      .tx_valid, .tx_ready, .tx_byte, .rx_valid, .rx_ready, .rx_byte,
      .picked_byte, .jptr, .buf_addr, .len_left, .len_last,
      .ld_jptr, .jptr_in, .adv_jptr, .ld_buf, .buf_in, .buf_inc,
      .ld_len, .len_in, .len_dec
   );

   wlk_cursor #(.AW(AW)) u_cursor (
      .clk, .rst_n, .ld_jptr, .jptr_in, .adv_jptr, .ld_buf, .buf_in,
      .buf_inc, .ld_len, .len_in, .len_dec, .jptr, .buf_addr,
      .len_left, .len_last
   );

   wlk_lane #(.BIG_LANES(BIG_LANES)) u_lane (
      .word_i (rsp_data),
      .sel_i  (buf_addr[1:0]),
      .byte_o (picked_byte)
   );

   wlk_event u_event (
      .clk, .rst_n,
      .set_i    (done_set),
      .clr_i    (clr_done),
      .irq_en_i (irq_en),
      .done_o   (done_flag),
      .irq_o    (irq)
   );
endmodule

// File: tb/joblist_dma_walker_bench.sv
module joblist_dma_walker_bench;
   localparam int AW = 16;

   logic clk = 1'b0;
   logic rst_n, start, irq_en, clr_done;
   logic [AW-1:0] list_ptr;
   logic busy, done_flag, irq;
   logic rd_valid, rd_ready, rsp_valid;
   logic [AW-1:0] rd_addr, wr_addr;
   logic [31:0] rsp_data;
   logic wr_valid, wr_ready, tx_valid, tx_ready, rx_valid, rx_ready;
   logic [7:0] wr_byte, tx_byte, rx_byte;

   always #2 clk = ~clk;

   joblist_dma_walker #(.AW(AW), .BIG_LANES(0)) u_joblist_dma_walker (
      .clk, .rst_n, .start, .list_ptr, .irq_en, .clr_done, .busy, .done_flag, .irq,
      .rd_valid, .rd_ready, .rd_addr, .rsp_valid, .rsp_data,
      .wr_valid, .wr_ready, .wr_addr, .wr_byte,
      .tx_valid, .tx_ready, .tx_byte, .rx_valid, .rx_ready, .rx_byte
   );

   int n_chk = 0, n_fail = 0;
   int tx_seen = 0, wr_seen = 0;
   bit stall_on = 0;
   logic [31:0] mem [0:1023];
   logic [7:0]  exp_tx[$];
   logic [23:0] exp_wr[$];
   logic [7:0]  rx_q[$];

   task automatic chk(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] mem_byte(int a);
      logic [31:0] w;
      w = mem[(a >> 2) & 1023] >> (8 * (a % 4));
      return w[7:0];
   endfunction

   task automatic put_job(int at, int bufa, logic [31:0] attr);
      mem[at >> 2]       = bufa;
      mem[(at >> 2) + 1] = attr;
   endtask

   task automatic exp_tx_job(int bufa, int len);
      for (int i = 0; i < len; i++) exp_tx.push_back(mem_byte(bufa + i));
   endtask

   task automatic rx_job(int bufa, int len, int seed);
      for (int i = 0; i < len; i++) begin
         logic [7:0] b;
         b = 8'(seed + i * 13);
         rx_q.push_back(b);
         exp_wr.push_back({16'(bufa + i), b});
      end
   endtask

   // bus model and scoreboard monitor, all at negedge
   initial begin
      bit pend;
      logic [AW-1:0] paddr;
      int cyc;
      pend = 0; paddr = '0; cyc = 0;
      rd_ready = 0; rsp_valid = 0; rsp_data = '0;
      wr_ready = 0; tx_ready = 0; rx_valid = 0; rx_byte = '0;
      forever begin
         @(negedge clk);
         cyc++;
         rsp_valid = pend;
         if (pend) rsp_data = mem[paddr[11:2]];
         pend = 0;
         rd_ready = !(stall_on && (cyc % 3 == 0));
         if (rd_valid && rd_ready) begin
            pend  = 1;
            paddr = rd_addr;
         end
         wr_ready = !(stall_on && (cyc % 4 == 1));
         if (wr_valid && wr_ready) begin
            logic [31:0] w;
            wr_seen++;
            chk(exp_tx.size() == 0, "R8", "write before tx done", exp_tx.size(), 0);
            if (exp_wr.size() == 0) chk(0, "R7", "unexpected write", wr_addr, 0);
            else begin
               logic [23:0] e;
               e = exp_wr.pop_front();
               chk({wr_addr, wr_byte} == e, "R7", "write addr/byte", {wr_addr, wr_byte}, e);
            end
            w = mem[wr_addr[11:2]];
            w[8 * wr_addr[1:0] +: 8] = wr_byte;
            mem[wr_addr[11:2]] = w;
         end
         tx_ready = !(stall_on && (cyc % 2 == 0));
         if (tx_valid && tx_ready) begin
            tx_seen++;
            if (exp_tx.size() == 0) chk(0, "R6", "unexpected tx byte", tx_byte, 0);
            else begin
               logic [7:0] e;
               e = exp_tx.pop_front();
               chk(tx_byte == e, "R6", "tx byte", tx_byte, e);
            end
         end
         rx_valid = (rx_q.size() > 0) && !(stall_on && (cyc % 5 == 2));
         if (rx_q.size() > 0) rx_byte = rx_q[0];
         if (rx_valid && rx_ready) void'(rx_q.pop_front());
      end
   end

   task automatic run_list(logic [AW-1:0] ptr, int intr_at);
      int n;
      @(negedge clk); start = 1; list_ptr = ptr;
      @(negedge clk); start = 0;
      chk(busy == 1, "R1", "busy after start", busy, 1);
      if (intr_at > 0) begin
         repeat (intr_at) @(negedge clk);
         chk(busy == 1, "R10", "still busy at second start", busy, 1);
         start = 1; list_ptr = 16'h0110;
         @(negedge clk); start = 0;
      end
      n = 0;
      while (!done_flag && n < 5000) begin @(negedge clk); n++; end
      chk(done_flag == 1, "R9", "done raised", done_flag, 1);
      chk(busy == 0, "R9", "idle with done", busy, 0);
      chk(irq == irq_en, "R9", "irq gating", irq, irq_en);
      chk(exp_tx.size() == 0, "R6", "tx bytes left", exp_tx.size(), 0);
      chk(exp_wr.size() == 0, "R7", "writes left", exp_wr.size(), 0);
      repeat (3) @(negedge clk);
      chk(done_flag == 1, "R9", "done sticky", done_flag, 1);
      clr_done = 1;
      @(negedge clk); clr_done = 0;
      chk(done_flag == 0, "R9", "done cleared", done_flag, 0);
      chk(irq == 0, "R9", "irq cleared", irq, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL R1 watchdog act=hung exp=finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      int t0, w0;
      for (int w = 0; w < 1024; w++)
         for (int k = 0; k < 4; k++) mem[w][8 * k +: 8] = 8'((4 * w + k) * 7 + 3);
      mem[16'h100 >> 2] = 32'h200; mem[16'h104 >> 2] = 32'h2C0;
      put_job(16'h200, 16'h400, 32'h3F00_0004);
      put_job(16'h208, 16'h410, 32'h4000_0004);
      put_job(16'h210, 16'h420, 32'h8000_0005);
      put_job(16'h218, 0, 0);
      put_job(16'h2C0, 0, 0);
      mem[16'h108 >> 2] = 32'h2C0; mem[16'h10C >> 2] = 32'h2C0;
      mem[16'h110 >> 2] = 32'h2C0; mem[16'h114 >> 2] = 32'h300;
      put_job(16'h300, 16'h800, 32'h0000_0006);
      put_job(16'h308, 0, 0);
      mem[16'h118 >> 2] = 32'h340; mem[16'h11C >> 2] = 32'h2C0;
      put_job(16'h340, 16'h433, 32'hC500_0003);
      put_job(16'h348, 16'h450, 32'h7F00_0000);
      put_job(16'h350, 16'h461, 32'h0000_0002);
      put_job(16'h358, 0, 0);
      mem[16'h120 >> 2] = 32'h380; mem[16'h124 >> 2] = 32'h3C0;
      put_job(16'h380, 16'h480, 32'h0000_0003);
      put_job(16'h388, 0, 0);
      put_job(16'h3C0, 16'h900, 32'h0100_0004);
      put_job(16'h3C8, 0, 0);

      rst_n = 0; start = 0; list_ptr = '0; irq_en = 0; clr_done = 0;
      repeat (3) @(negedge clk);
      chk(busy == 0 && done_flag == 0 && irq == 0, "R1", "reset flags", {busy, done_flag, irq}, 0);
      chk(rd_valid == 0 && wr_valid == 0 && tx_valid == 0 && rx_ready == 0, "R1", "reset ports",
          {rd_valid, wr_valid, tx_valid, rx_ready}, 0);
      rst_n = 1;
      repeat (2) @(negedge clk);

      // transmit packet: command, address, data jobs (R2)
      t0 = tx_seen;
      exp_tx_job(16'h400, 4); exp_tx_job(16'h410, 4); exp_tx_job(16'h420, 5);
      run_list(16'h100, 0);
      chk(tx_seen - t0 == 13, "R2", "tx byte count of 3 jobs", tx_seen - t0, 13);

      irq_en = 1;
      // both lists empty (R4)
      t0 = tx_seen; w0 = wr_seen;
      run_list(16'h108, 0);
      chk(tx_seen - t0 == 0 && wr_seen - w0 == 0, "R4", "empty lists move nothing",
          (tx_seen - t0) + (wr_seen - w0), 0);

      // receive-only packet (R7)
      rx_job(16'h800, 6, 8'h5A);
      run_list(16'h110, 0);
      for (int i = 0; i < 6; i++)
         chk(mem_byte(16'h800 + i) == 8'(8'h5A + i * 13), "R7", "stored byte",
             mem_byte(16'h800 + i), 8'(8'h5A + i * 13));

      // attribute bits, zero-length skip, unaligned lanes (R3, R5)
      t0 = tx_seen;
      exp_tx_job(16'h433, 3); exp_tx_job(16'h461, 2);
      run_list(16'h118, 0);
      chk(tx_seen - t0 == 5, "R3", "count from bits 23:0 only; R5 zero job skipped",
          tx_seen - t0, 5);

      // both lists, backpressure, rx bytes available early (R8, R11)
      stall_on = 1;
      t0 = tx_seen; w0 = wr_seen;
      exp_tx_job(16'h480, 3);
      rx_job(16'h900, 4, 8'h11);
      run_list(16'h120, 0);
      chk(tx_seen - t0 == 3 && wr_seen - w0 == 4, "R11", "beats under stalls",
          (tx_seen - t0) * 16 + (wr_seen - w0), 16'h34);

      // start while busy is ignored (R10)
      t0 = tx_seen; w0 = wr_seen;
      exp_tx_job(16'h400, 4); exp_tx_job(16'h410, 4); exp_tx_job(16'h420, 5);
      run_list(16'h100, 15);
      repeat (20) @(negedge clk);
      chk(busy == 0 && done_flag == 0, "R10", "no second walk", {busy, done_flag}, 0);
      chk(tx_seen - t0 == 13 && wr_seen - w0 == 0, "R10", "stream unchanged",
          (tx_seen - t0) * 16 + (wr_seen - w0), 16'hD0);

      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule